// File: doc/BRIEF.md
# USB Device Interrupt Status Unit

This block keeps the interrupt status flags of a USB device controller. An endpoint status register records received setup packets. It also records a second setup packet that arrives before software has dealt with the first one, which happens when the host retries after a corrupted handshake. A DMA status register records transfer completion and transfer errors from the DMA master channel. The packet engine and the DMA engine send single-cycle event pulses to set these flags. Software reads the flags and clears them by writing 1 through a simple register port.

The block produces one global interrupt line, registered by one cycle. A DMA completion reaches this line only when the completion enable bit from the DMA channel configuration is set. A DMA error always reaches it, and so does any pending endpoint flag.

Top module: `usbd_irq_unit`

## Requirements
- R1: After reset every flag is 0, `reg_rdata` is 0 and `irq_out` is 0.
- R2: Writing 0 to a flag bit leaves that bit unchanged. All bits of either register other than bits 0 and 1 read as 0.
- R3: Writing 1 to a flag bit clears it, unless an event sets the same flag in the same cycle.
- R4: A `setup_evt` pulse sets the SETUP flag, which is bit 0 of the endpoint register (`reg_addr` = 0).
- R5: The multiple-setup flag (endpoint bit 1) sets when `setup_evt` arrives while SETUP is already pending and the same cycle does not write 1 to SETUP. If SETUP is cleared in that same cycle, the multiple-setup flag keeps its previous value.
- R6: If one write sets endpoint bits 0 and 1 in the cycle a further `setup_evt` arrives while SETUP is pending, then the multiple-setup flag is 0 afterwards and SETUP is 1.
- R7: For SETUP, DMA completion and DMA error, an event in the same cycle as a write-1 clear leaves the flag set. The same holds for multiple-setup when only bit 1 is written.
- R8: In the DMA register (`reg_addr` = 1), bit 0 is the completion flag, set by `dma_done_evt`, and bit 1 is the error flag, set by `dma_err_evt`.
- R9: `irq_out` on each edge takes the value (completion AND `dma_done_en`) OR error OR SETUP OR multiple-setup, using the flag values held before that edge.
- R10: `reg_rdata` on each edge takes the value of the register selected by `reg_addr`, as held before that edge. Reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_evt | input | 1 | Setup packet received on the endpoint (pulse) |
| dma_done_evt | input | 1 | DMA transfer completed (pulse) |
| dma_err_evt | input | 1 | DMA transfer error (pulse) |
| dma_done_en | input | 1 | Completion interrupt enable from the DMA channel configuration |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 endpoint, 1 DMA |
| reg_wdata | input | REG_W | Write data, 1 clears a bit |
| reg_rdata | output | REG_W | Registered read data |
| irq_out | output | 1 | Registered global interrupt |

## Verification
Directed cases cover the event-versus-clear collisions one at a time: a retried setup with no clear, with only bit 1 cleared, with only bit 0 cleared, and with both cleared. These show that the multiple-setup rule differs from the plain set-wins rule. Further directed cases toggle `dma_done_en` with completion pending and then with only an error pending, which shows which source the mask acts on. Random cycles mix events, writes of random data to both addresses and the enable. The output is compared each cycle against a bench model built from the requirements, which exposes wrong bit positions, clears that are lost or leak into other bits, and a missing one-cycle register stage.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  // register select values
  localparam logic ADDR_EP  = 1'b0;
  localparam logic ADDR_DMA = 1'b1;
  // bit positions in both registers
  localparam int BIT_LO = 0;  // SETUP / DMA completion
  localparam int BIT_HI = 1;  // multiple-setup / DMA error
endpackage

// File: rtl/usbd_ep_flags.sv
module usbd_ep_flags (
  input  logic clk,
  input  logic rst,
  input  logic setup_evt,
  input  logic clr_setup,
  input  logic clr_multi,
  output logic setup_q,
  output logic multi_q
);
  logic multi_set;
  // a retry counts only when the earlier setup stays pending this cycle
  assign multi_set = setup_evt & setup_q & ~clr_setup;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= 1'b0;
      multi_q <= 1'b0;
    end else begin
      setup_q <= setup_evt | (setup_q & ~clr_setup);
      multi_q <= multi_set | (multi_q & ~clr_multi);
    end
  end

  // R4: setup event always leaves SETUP pending
  a_r4_setup_sets: assert property (@(posedge clk) disable iff (rst)
    setup_evt |=> setup_q);
  // R6: collision of both clears with a retried setup
  a_r6_collision: assert property (@(posedge clk) disable iff (rst)
    (setup_evt && setup_q && clr_setup && clr_multi) |=> (setup_q && !multi_q));
  // R5: retry against an uncleared pending setup marks multiple-setup
  a_r5_multi_sets: assert property (@(posedge clk) disable iff (rst)
    (setup_evt && setup_q && !clr_setup) |=> multi_q);
  // R2: no event and no clear keeps both flags
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!setup_evt && !clr_setup && !clr_multi) |=> ($stable(setup_q) && $stable(multi_q)));
endmodule

// File: rtl/usbd_dma_flags.sv
module usbd_dma_flags (
  input  logic clk,
  input  logic rst,
  input  logic done_evt,
  input  logic err_evt,
  input  logic clr_done,
  input  logic clr_err,
  output logic done_q,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_evt | (done_q & ~clr_done);
      err_q  <= err_evt  | (err_q  & ~clr_err);
    end
  end

  // R7: set beats a simultaneous clear
  a_r7_done_set_wins: assert property (@(posedge clk) disable iff (rst)
    (done_evt && clr_done) |=> done_q);
  a_r7_err_set_wins: assert property (@(posedge clk) disable iff (rst)
    (err_evt && clr_err) |=> err_q);
  // R3: clear without event empties the flag
  a_r3_err_clears: assert property (@(posedge clk) disable iff (rst)
    (!err_evt && clr_err) |=> !err_q);
endmodule

// File: rtl/usbd_irq_merge.sv
module usbd_irq_merge (
  input  logic clk,
  input  logic rst,
  input  logic done_q,
  input  logic done_en,
  input  logic err_q,
  input  logic setup_q,
  input  logic multi_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (done_q & done_en) | err_q | setup_q | multi_q;
  end

  // R9: error reaches the line regardless of the enable
  a_r9_err_unmasked: assert property (@(posedge clk) disable iff (rst)
    err_q |=> irq_q);
  // R9: masked completion alone keeps the line low
  a_r9_done_masked: assert property (@(posedge clk) disable iff (rst)
    (!done_en && !err_q && !setup_q && !multi_q) |=> !irq_q);
endmodule

// File: rtl/usbd_irq_unit.sv
module usbd_irq_unit #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_evt,
  input  logic             dma_done_evt,
  input  logic             dma_err_evt,
  input  logic             dma_done_en,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_out
);
  import usbd_irq_pkg::*;
  localparam int PAD_W = REG_W - 2;

  logic wr_ep, wr_dma;
  logic setup_q, multi_q, done_q, err_q;
  logic [REG_W-1:0] ep_word, dma_word;

  assign wr_ep  = reg_wr && (reg_addr == ADDR_EP);
  assign wr_dma = reg_wr && (reg_addr == ADDR_DMA);

  usbd_ep_flags u_ep (
    .clk(clk), .rst(rst), .setup_evt(setup_evt),
    .clr_setup(wr_ep & reg_wdata[BIT_LO]),
    .clr_multi(wr_ep & reg_wdata[BIT_HI]),
    .setup_q(setup_q), .multi_q(multi_q)
  );

  usbd_dma_flags u_dma (
    .clk(clk), .rst(rst), .done_evt(dma_done_evt), .err_evt(dma_err_evt),
    .clr_done(wr_dma & reg_wdata[BIT_LO]),
    .clr_err(wr_dma & reg_wdata[BIT_HI]),
    .done_q(done_q), .err_q(err_q)
  );

  usbd_irq_merge u_irq (
    .clk(clk), .rst(rst), .done_q(done_q), .done_en(dma_done_en),
    .err_q(err_q), .setup_q(setup_q), .multi_q(multi_q), .irq_q(irq_out)
  );

  assign ep_word  = {{PAD_W{1'b0}}, multi_q, setup_q};
  assign dma_word = {{PAD_W{1'b0}}, err_q, done_q};

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= (reg_addr == ADDR_DMA) ? dma_word : ep_word;
  end

  // R2: unused bits never read as 1
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:2] == '0);
  // R10: a read of the DMA register shows its completion flag one cycle later
  a_r10_read_dma: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_DMA) |=> (reg_rdata[0] == $past(done_q)));
endmodule

// File: tb/usbd_irq_unit_bench.sv
module usbd_irq_unit_bench;
  localparam int W = 16;
  logic clk = 0, rst = 1;
  logic setup_evt = 0, dma_done_evt = 0, dma_err_evt = 0, dma_done_en = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq_out;
  int checks = 0, fails = 0;
  logic m_setup = 0, m_multi = 0, m_done = 0, m_err = 0;

  always #5 clk = ~clk;

  usbd_irq_unit #(.REG_W(W)) u_usbd_irq_unit (
    .clk(clk), .rst(rst), .setup_evt(setup_evt), .dma_done_evt(dma_done_evt),
    .dma_err_evt(dma_err_evt), .dma_done_en(dma_done_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [W-1:0] exp_word(input logic a);
    return a ? {{(W-2){1'b0}}, m_err, m_done} : {{(W-2){1'b0}}, m_multi, m_setup};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive, model update, compare after the edge
  task automatic step(input logic s, input logic d, input logic e, input logic wr,
                      input logic a, input logic [W-1:0] wd, input logic en, input string tag);
    logic [W-1:0] erd;
    logic eirq, cs, cm, cd, ce;
    @(negedge clk);
    setup_evt = s; dma_done_evt = d; dma_err_evt = e; reg_wr = wr;
    reg_addr = a; reg_wdata = wd; dma_done_en = en;
    erd  = exp_word(a);
    eirq = (m_done & en) | m_err | m_setup | m_multi;
    cs = wr & !a & wd[0]; cm = wr & !a & wd[1];
    cd = wr & a & wd[0];  ce = wr & a & wd[1];
    m_multi = (s & m_setup & ~cs) | (m_multi & ~cm);
    m_setup = s | (m_setup & ~cs);
    m_done  = d | (m_done & ~cd);
    m_err   = e | (m_err & ~ce);
    @(posedge clk); #1;
    check({tag, " rdata"}, reg_rdata, erd);
    check({tag, " irq"}, {{(W-1){1'b0}}, irq_out}, {{(W-1){1'b0}}, eirq});
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    step(0,0,0,0,0,'0,1,"R1 reset ep");
    step(0,0,0,0,1,'0,1,"R1 reset dma");
    // R4: setup sets bit 0
    step(1,0,0,0,0,'0,0,"R4 setup evt");
    step(0,0,0,0,0,'0,0,"R4 readback");
    // R2: writing zeros leaves flags
    step(0,0,0,1,0,16'hFFFC,0,"R2 write zero bits");
    step(0,0,0,0,0,'0,0,"R2 readback");
    // R5: retry while pending
    step(1,0,0,0,0,'0,0,"R5 retry");
    step(0,0,0,0,0,'0,0,"R5 readback");
    // R6: both cleared in retry cycle
    step(1,0,0,1,0,16'h0003,0,"R6 collision");
    step(0,0,0,0,0,'0,0,"R6 readback");
    // R5: clearing SETUP in retry cycle keeps multi at 0
    step(1,0,0,1,0,16'h0001,0,"R5 clr setup retry");
    step(0,0,0,0,0,'0,0,"R5 readback2");
    // R7: multi set beats bit-1 clear
    step(1,0,0,1,0,16'h0002,0,"R7 multi set wins");
    step(0,0,0,0,0,'0,0,"R7 readback");
    // R3: clear both
    step(0,0,0,1,0,16'h0003,0,"R3 clear ep");
    step(0,0,0,0,0,'0,0,"R3 readback");
    step(0,0,0,0,0,'0,0,"R9 idle low");
    // R8 / R9: completion masked then enabled
    step(0,1,0,0,1,'0,0,"R8 done evt");
    step(0,0,0,0,1,'0,0,"R9 done masked");
    step(0,0,0,0,1,'0,1,"R9 done enabled");
    step(0,0,0,1,1,16'h0001,0,"R3 clear done");
    // R8 / R9: error unmasked
    step(0,0,1,0,1,'0,0,"R8 err evt");
    step(0,0,0,0,1,'0,0,"R9 err unmasked");
    // R7: error set beats clear
    step(0,0,1,1,1,16'h0002,0,"R7 err set wins");
    step(0,0,0,0,1,'0,0,"R10 read no side effect");
    step(0,0,0,0,1,'0,0,"R10 read again");
    step(0,0,0,1,1,16'hFFFF,0,"R3 clear dma");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] wd;
      wd = W'($urandom);
      step(($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
           ($urandom % 3) == 0, 1'($urandom), wd, 1'($urandom), "R7 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule